// File: doc/BRIEF.md
# Write-Through Set-Associative L1 Data Cache

This block is a first-level data cache placed between a single load/store port and a lower memory level. It holds 8 KB as 4 ways of 64-byte lines, which gives 32 sets. Every store is passed straight on to the lower level, so lines never carry modified state and an eviction never writes anything back. Filling a line here does not change what the lower level holds.

A request is accepted when `req_valid` and `req_ready` are both high at a rising edge. A load that hits returns its word on `rsp_valid`/`rsp_data` two cycles after acceptance, and hits can be accepted back to back. A load that misses holds `req_ready` low while it fetches its aligned 64-byte line from the lower level as one read request followed by 16 word beats. It then installs the line and returns the requested word. Only one miss is outstanding at a time. A store that misses is forwarded to the lower level without allocating a line. Replacement uses a 3-bit pseudo-LRU tree per set.

Top module: `wt_dcache`

## Requirements
- R1: Address bits [5:0] are the byte offset, bits [5:2] select the 32-bit word in a line, bits [10:6] select one of 32 sets and bits [31:11] form the tag. Lines that differ only in set index never displace each other.
- R2: Every accepted store produces exactly one write request to the lower level. The request carries the store's address, data and 4-bit byte enables, and this holds for hits and misses alike.
- R3: A store that misses does not allocate a line and issues no line read; a later load to that address misses and returns the stored data.
- R4: A load that hits raises `rsp_valid` exactly two clock edges after the edge that accepted it, with the current word, and issues no lower-level read.
- R5: A load that misses issues one read request whose address has bits [5:0] zero. `req_ready` stays low until all 16 beats have arrived (beat k is word k of the line). The load then returns the requested word.
- R6: A store that hits updates only the bytes whose enable bit is set (bit b covers data bits 8b+7..8b), and a later hit returns the merged word.
- R7: The victim is the lowest-numbered invalid way of the set if one exists. Otherwise it is taken from the tree: bit0=0 selects ways 0/1, where bit1 picks way 1 when set and way 0 when clear. bit0=1 selects ways 2/3, where bit2 picks way 3 when set and way 2 when clear. Each hit or fill to way w sets bit0 to the other pair and the pair bit to the other way of the pair.
- R8: Reset invalidates every line and clears every tree, so the first load to any address misses; after reset `req_ready`=1, `rsp_valid`=0, `mem_req_valid`=0.
- R9: Evictions cause no write traffic: the number of lower-level writes equals the number of stores, and the number of line reads equals the number of load misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 32 | Byte address (word aligned) |
| req_wdata | input | 32 | Store data |
| req_be | input | 4 | Store byte enables |
| rsp_valid | output | 1 | Load data valid |
| rsp_data | output | 32 | Load data |
| mem_req_valid | output | 1 | Lower-level request present |
| mem_req_ready | input | 1 | Lower level accepts the request |
| mem_req_write | output | 1 | 1 = word write, 0 = line read |
| mem_req_addr | output | 32 | Write address or line base address |
| mem_req_wdata | output | 32 | Write data |
| mem_req_be | output | 4 | Write byte enables |
| mem_rsp_valid | input | 1 | Fill beat valid |
| mem_rsp_data | input | 32 | Fill beat data, words in ascending order |

## Verification
The hardest state to reach from the ports is a full set whose tree bits have been bent by hits in a chosen order, so that the next fill must evict one particular way and not the oldest one. The stimulus fills one set with five lines spaced 2048 bytes apart and touches two of them between fills. It then reads back every alias and checks which ones miss by counting line reads. A randomized mix of stores and loads over six aliasing lines in two sets follows, with varied byte enables and a lower level whose latency, request acceptance and beat gaps keep changing.

// File: rtl/wt_dcache_pkg.sv
package wt_dcache_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_FREQ  = 2'd1,
    ST_FWAIT = 2'd2
  } fsm_t;

  // way selected by a 3-bit tree: bit0 picks the pair, bit1/bit2 the way in it
  function automatic logic [1:0] plru_pick(input logic [2:0] t);
    return t[0] ? {1'b1, t[2]} : {1'b0, t[1]};
  endfunction

  // tree after touching way w: every bit on the path points away from w
  function automatic logic [2:0] plru_touch(input logic [2:0] t, input logic [1:0] w);
    logic [2:0] n;
    n = t;
    n[0] = ~w[1];
    if (w[1]) n[2] = ~w[0];
    else      n[1] = ~w[0];
    return n;
  endfunction

  function automatic logic [1:0] onehot_to_way(input logic [3:0] v);
    logic [1:0] r;
    r = 2'd0;
    for (int i = 0; i < 4; i++) if (v[i]) r = 2'(i);
    return r;
  endfunction

endpackage

// File: rtl/wt_dcache_tags.sv
module wt_dcache_tags #(
  parameter int SETS  = 32,
  parameter int SET_W = 5,
  parameter int TAG_W = 21
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] look_set,
  input  logic [TAG_W-1:0] look_tag,
  output logic [3:0]       hit_vec,
  output logic [3:0]       valid_vec,
  input  logic             inst_en,
  input  logic [SET_W-1:0] inst_set,
  input  logic [1:0]       inst_way,
  input  logic [TAG_W-1:0] inst_tag
);

  for (genvar w = 0; w < 4; w++) begin : g_way
    logic [TAG_W-1:0] tag_q [SETS];
    logic [SETS-1:0]  val_q;
    logic             sel;

    assign sel = inst_en && (inst_way == 2'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   val_q <= '0;
      else if (sel) val_q[inst_set] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (sel) tag_q[inst_set] <= inst_tag;
    end

    assign valid_vec[w] = val_q[look_set];
    assign hit_vec[w]   = val_q[look_set] && (tag_q[look_set] == look_tag);
  end

  // a tag is never resident in two ways of one set
  p_single_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

endmodule

// File: rtl/wt_dcache_data.sv
module wt_dcache_data #(
  parameter int SETS   = 32,
  parameter int SET_W  = 5,
  parameter int WORDS  = 16,
  parameter int WRD_W  = 4,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic [SET_W-1:0]       rd_set,
  input  logic [WRD_W-1:0]       rd_word,
  output logic [3:0][DATA_W-1:0] rd_words,
  input  logic                   wr_en,
  input  logic [1:0]             wr_way,
  input  logic [SET_W-1:0]       wr_set,
  input  logic [WRD_W-1:0]       wr_word,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [DATA_W/8-1:0]    wr_be
);

  localparam int DEPTH = 4 * SETS * WORDS;
  localparam int BE_W  = DATA_W / 8;

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [2+SET_W+WRD_W-1:0] widx;

  assign widx = {wr_way, wr_set, wr_word};

  always_ff @(posedge clk) begin
    if (wr_en) begin
      for (int b = 0; b < BE_W; b++)
        if (wr_be[b]) mem_q[widx][b*8 +: 8] <= wr_data[b*8 +: 8];
    end
  end

  for (genvar w = 0; w < 4; w++) begin : g_rd
    assign rd_words[w] = mem_q[{2'(w), rd_set, rd_word}];
  end

endmodule

// File: rtl/wt_dcache_plru.sv
module wt_dcache_plru
  import wt_dcache_pkg::*;
#(
  parameter int SETS  = 32,
  parameter int SET_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             touch_en,
  input  logic [SET_W-1:0] touch_set,
  input  logic [1:0]       touch_way,
  input  logic [SET_W-1:0] pick_set,
  input  logic [3:0]       pick_valid,
  output logic [1:0]       victim
);

  logic [2:0] tree_q [SETS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= 3'b000;
    end else if (touch_en) begin
      tree_q[touch_set] <= plru_touch(tree_q[touch_set], touch_way);
    end
  end

  always_comb begin
    victim = plru_pick(tree_q[pick_set]);
    for (int w = 3; w >= 0; w--)
      if (!pick_valid[w]) victim = 2'(w);
  end

  // after a touch the tree of that set no longer names the touched way
  p_turn_away_r7: assert property (@(posedge clk) disable iff (!rst_n)
    touch_en |=> (plru_pick(tree_q[$past(touch_set)]) != $past(touch_way)));

endmodule

// File: rtl/wt_dcache.sv
module wt_dcache
  import wt_dcache_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 32,
  parameter int LINE_BYTES = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  output logic                req_ready,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  input  logic [DATA_W/8-1:0] req_be,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_data,
  output logic                mem_req_valid,
  input  logic                mem_req_ready,
  output logic                mem_req_write,
  output logic [ADDR_W-1:0]   mem_req_addr,
  output logic [DATA_W-1:0]   mem_req_wdata,
  output logic [DATA_W/8-1:0] mem_req_be,
  input  logic                mem_rsp_valid,
  input  logic [DATA_W-1:0]   mem_rsp_data
);

  localparam int BE_W   = DATA_W / 8;
  localparam int BOFF_W = $clog2(BE_W);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int SET_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - OFF_W - SET_W;
  localparam int WORDS  = LINE_BYTES / BE_W;
  localparam int WRD_W  = $clog2(WORDS);

  // stage 1: request under lookup
  logic              s1_v, s1_we, s1_fresh;
  logic [ADDR_W-1:0] s1_addr;
  logic [DATA_W-1:0] s1_wdata;
  logic [BE_W-1:0]   s1_be;
  // stage 2 and output
  logic              s2_v, rsp_v_q;
  logic [DATA_W-1:0] s2_d, rsp_d_q;
  // miss handling
  fsm_t              state;
  logic [1:0]        fill_way;
  logic [WRD_W-1:0]  fill_cnt;

  logic [SET_W-1:0]       s1_set;
  logic [TAG_W-1:0]       s1_tag;
  logic [WRD_W-1:0]       s1_word;
  logic [3:0]             hit_vec, valid_vec;
  logic [3:0][DATA_W-1:0] rd_words;
  logic [1:0]             hit_way, victim;

  // named internal events
  logic run, s1_hit, ld_go, st_go, ld_miss, s1_free, accept;
  logic fill_beat, fill_last, touch_en;
  logic [1:0] touch_way;

  assign s1_set  = s1_addr[OFF_W +: SET_W];
  assign s1_tag  = s1_addr[ADDR_W-1 -: TAG_W];
  assign s1_word = s1_addr[BOFF_W +: WRD_W];

  assign run       = (state == ST_RUN);
  assign s1_hit    = |hit_vec;
  assign hit_way   = onehot_to_way(hit_vec);
  assign ld_go     = run && s1_v && !s1_we && s1_hit;
  assign ld_miss   = run && s1_v && !s1_we && !s1_hit;
  assign st_go     = run && s1_v && s1_we && mem_req_ready;
  assign s1_free   = !s1_v || ld_go || st_go;
  assign req_ready = s1_free;
  assign accept    = req_valid && req_ready;

  assign fill_beat = (state == ST_FWAIT) && mem_rsp_valid;
  assign fill_last = fill_beat && (fill_cnt == WRD_W'(WORDS - 1));
  assign touch_en  = fill_last || ld_go || (st_go && s1_hit);
  assign touch_way = fill_last ? fill_way : hit_way;

  wt_dcache_tags #(.SETS(SETS), .SET_W(SET_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst_n(rst_n), .look_set(s1_set), .look_tag(s1_tag),
    .hit_vec(hit_vec), .valid_vec(valid_vec), .inst_en(fill_last),
    .inst_set(s1_set), .inst_way(fill_way), .inst_tag(s1_tag));

  wt_dcache_data #(.SETS(SETS), .SET_W(SET_W), .WORDS(WORDS), .WRD_W(WRD_W),
                   .DATA_W(DATA_W)) u_data (
    .clk(clk), .rd_set(s1_set), .rd_word(s1_word), .rd_words(rd_words),
    .wr_en(fill_beat || (st_go && s1_hit)),
    .wr_way(fill_beat ? fill_way : hit_way), .wr_set(s1_set),
    .wr_word(fill_beat ? fill_cnt : s1_word),
    .wr_data(fill_beat ? mem_rsp_data : s1_wdata),
    .wr_be(fill_beat ? {BE_W{1'b1}} : s1_be));

  wt_dcache_plru #(.SETS(SETS), .SET_W(SET_W)) u_plru (
    .clk(clk), .rst_n(rst_n), .touch_en(touch_en), .touch_set(s1_set),
    .touch_way(touch_way), .pick_set(s1_set), .pick_valid(valid_vec),
    .victim(victim));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_v     <= 1'b0;
      s1_fresh <= 1'b0;
      s2_v     <= 1'b0;
      rsp_v_q  <= 1'b0;
      state    <= ST_RUN;
      fill_way <= 2'd0;
      fill_cnt <= '0;
    end else begin
      if (s1_free) s1_v <= req_valid;
      s1_fresh <= accept;
      s2_v     <= ld_go;
      rsp_v_q  <= s2_v;
      case (state)
        ST_RUN:   if (ld_miss) begin state <= ST_FREQ; fill_way <= victim; end
        ST_FREQ:  if (mem_req_ready) begin state <= ST_FWAIT; fill_cnt <= '0; end
        ST_FWAIT: if (fill_beat) begin
                    fill_cnt <= fill_cnt + WRD_W'(1);
                    if (fill_last) state <= ST_RUN;
                  end
        default:  state <= ST_RUN;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      s1_we    <= req_write;
      s1_addr  <= req_addr;
      s1_wdata <= req_wdata;
      s1_be    <= req_be;
    end
    s2_d    <= rd_words[hit_way];
    rsp_d_q <= s2_d;
  end

  assign rsp_valid     = rsp_v_q;
  assign rsp_data      = rsp_d_q;
  assign mem_req_valid = (state == ST_FREQ) || (run && s1_v && s1_we);
  assign mem_req_write = (state != ST_FREQ);
  assign mem_req_addr  = (state == ST_FREQ) ? {s1_addr[ADDR_W-1:OFF_W], OFF_W'(0)} : s1_addr;
  assign mem_req_wdata = s1_wdata;
  assign mem_req_be    = (state == ST_FREQ) ? {BE_W{1'b1}} : s1_be;

  // a freshly accepted load that hits answers two edges after acceptance
  p_hit_two_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (s1_fresh && ld_go) |-> ##2 rsp_valid);
  // the port is closed while a miss is being served
  p_stall_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_RUN) |-> !req_ready);
  // line reads are aligned to the line size
  p_line_align_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_write) |-> (mem_req_addr[OFF_W-1:0] == '0));
  // an invalid way is always preferred as victim
  p_victim_free_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_miss && !(&valid_vec)) |-> !valid_vec[victim]);
  // a store leaving stage 1 is forwarded with its own address
  p_store_fwd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    st_go |-> (mem_req_valid && mem_req_write && mem_req_addr == s1_addr));

endmodule

// File: tb/sim_wt_dcache.sv
module sim_wt_dcache;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic        req_ready, rsp_valid;
  logic [31:0] rsp_data;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b1;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic [3:0]  mem_req_be;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  always #5 clk = ~clk;

  wt_dcache u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_be(req_be), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_req_be(mem_req_be),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  int checks = 0, failures = 0, cyc = 0;
  int rd_count = 0, wr_count = 0, stores = 0, misses = 0;
  logic [31:0] last_wa, last_wd, last_rd;
  logic [3:0]  last_be;
  bit          exp_rsp = 0;

  logic [31:0] lower [int];
  logic [31:0] gold  [int];

  // behavioural cache model
  int       m_tag [32][4];
  bit       m_val [32][4];
  bit [2:0] m_tree [32];

  function automatic logic [31:0] seed_word(int wa);
    return (32'(wa) * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction
  function automatic logic [31:0] lower_rd(int wa);
    return lower.exists(wa) ? lower[wa] : seed_word(wa);
  endfunction
  function automatic logic [31:0] gold_rd(int wa);
    return gold.exists(wa) ? gold[wa] : seed_word(wa);
  endfunction
  function automatic logic [31:0] merge(logic [31:0] o, logic [31:0] n, logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  function automatic int m_find(logic [31:0] a);
    int s, t;
    s = int'((a >> 6) & 31);
    t = int'(a >> 11);
    for (int w = 0; w < 4; w++) if (m_val[s][w] && m_tag[s][w] == t) return w;
    return -1;
  endfunction
  function automatic void m_touch(int s, int w);
    m_tree[s][0] = (w / 2 == 0);
    if (w / 2 == 0) m_tree[s][1] = (w % 2 == 0);
    else            m_tree[s][2] = (w % 2 == 0);
  endfunction
  function automatic void m_access(bit we, logic [31:0] a);
    int s, w, pair;
    s = int'((a >> 6) & 31);
    w = m_find(a);
    if (w >= 0) begin m_touch(s, w); return; end
    if (we) return;
    w = -1;
    for (int k = 3; k >= 0; k--) if (!m_val[s][k]) w = k;
    if (w < 0) begin
      pair = m_tree[s][0] ? 1 : 0;
      w = pair * 2 + (m_tree[s][1 + pair] ? 1 : 0);
    end
    m_val[s][w] = 1;
    m_tag[s][w] = int'(a >> 11);
    m_touch(s, w);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // lower memory: everything happens at the falling edge
  int          fill_pend = 0, fill_dly = 0, fill_beat = 0;
  logic [31:0] fill_base;
  always @(negedge clk) begin
    cyc++;
    mem_req_ready = (cyc % 3) != 2;
    if (fill_pend != 0) begin
      if (fill_dly > 0) begin
        fill_dly--;
        mem_rsp_valid = 1'b0;
      end else begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = lower_rd(int'((fill_base >> 2) + 32'(fill_beat)));
        fill_beat++;
        if (fill_beat == 16) fill_pend = 0;
        else fill_dly = (fill_beat % 3 == 0) ? 1 : 0;
      end
    end else mem_rsp_valid = 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        wr_count++;
        last_wa = mem_req_addr; last_wd = mem_req_wdata; last_be = mem_req_be;
        lower[int'(mem_req_addr >> 2)] = merge(lower_rd(int'(mem_req_addr >> 2)),
                                               mem_req_wdata, mem_req_be);
      end else begin
        rd_count++;
        last_rd   = mem_req_addr;
        fill_base = mem_req_addr;
        fill_pend = 1;
        fill_beat = 0;
        fill_dly  = 1 + (rd_count % 4);
      end
    end
    if (rst_n && rsp_valid && !exp_rsp)
      chk(0, "R4", "response without a pending load", 32'(rsp_valid), 32'd0);
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic access(input bit we, input logic [31:0] a, input logic [31:0] wd,
                        input logic [3:0] be);
    int hitp, rd0, wr0;
    logic [31:0] exp;
    hitp = m_find(a);
    rd0 = rd_count; wr0 = wr_count;
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = wd; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(posedge clk);
    if (!we) exp_rsp = 1;
    @(negedge clk);
    req_valid = 1'b0;
    if (we) begin
      stores++;
      gold[int'(a >> 2)] = merge(gold_rd(int'(a >> 2)), wd, be);
      repeat (4) @(negedge clk);
      chk(wr_count == wr0 + 1, "R2", "write count", 32'(wr_count), 32'(wr0 + 1));
      chk(last_wa == a && last_wd == wd && last_be == be, "R2", "forwarded address",
          last_wa, a);
      chk(rd_count == rd0, "R3", "store caused no line read", 32'(rd_count), 32'(rd0));
    end else begin
      exp = gold_rd(int'(a >> 2));
      if (hitp >= 0) begin
        chk(!rsp_valid, "R4", "early response at +1", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        chk(!rsp_valid, "R4", "early response at +2 half", 32'(rsp_valid), 32'd0);
        @(negedge clk);
        chk(rsp_valid, "R4", "hit response after two edges", 32'(rsp_valid), 32'd1);
        chk(rsp_data == exp, "R4", "hit data", rsp_data, exp);
        chk(rd_count == rd0, "R4", "hit issued no read", 32'(rd_count), 32'(rd0));
      end else begin
        misses++;
        for (int i = 0; i < 400 && !rsp_valid; i++) @(negedge clk);
        chk(rsp_valid, "R5", "miss response arrived", 32'(rsp_valid), 32'd1);
        chk(rsp_data == exp, "R5", "miss data", rsp_data, exp);
        chk(rd_count == rd0 + 1, "R5", "one line read", 32'(rd_count), 32'(rd0 + 1));
        chk(last_rd == {a[31:6], 6'd0}, "R5", "line aligned read", last_rd,
            {a[31:6], 6'd0});
      end
      #1 exp_rsp = 0;
    end
    m_access(we, a);
  endtask

  initial begin
    for (int s = 0; s < 32; s++) begin
      m_tree[s] = 3'b000;
      for (int w = 0; w < 4; w++) begin m_val[s][w] = 0; m_tag[s][w] = 0; end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8", "ready after reset", 32'(req_ready), 32'd1);
    chk(rsp_valid == 1'b0, "R8", "no response after reset", 32'(rsp_valid), 32'd0);
    chk(mem_req_valid == 1'b0, "R8", "no lower request after reset", 32'(mem_req_valid), 32'd0);

    // R8 / R5 / R4: first load misses, repeats hit
    access(0, 32'h0000_1040, 0, 0);
    access(0, 32'h0000_1040, 0, 0);
    access(0, 32'h0000_107C, 0, 0);
    // R6: partial store hit then merged read
    access(1, 32'h0000_1044, 32'hDEAD_BEEF, 4'b0101);
    access(0, 32'h0000_1044, 0, 0);
    // R3: store miss, no allocation
    access(1, 32'h0004_2208, 32'h1234_5678, 4'b1111);
    access(0, 32'h0004_2208, 0, 0);
    // R1: one line in each of the 32 sets, all retained
    for (int s = 0; s < 32; s++) access(0, 32'h0001_0000 + 32'(s * 64), 0, 0);
    for (int s = 0; s < 32; s++) access(0, 32'h0001_0004 + 32'(s * 64), 0, 0);
    // R7: five aliases of set 5, tree bent by hits
    for (int k = 0; k < 4; k++) access(0, 32'h0020_0140 + 32'(k * 2048), 0, 0);
    access(0, 32'h0020_0140, 0, 0);
    access(0, 32'h0020_0140 + 32'(2 * 2048), 0, 0);
    access(0, 32'h0020_0140 + 32'(4 * 2048), 0, 0);
    for (int k = 0; k < 5; k++) access(0, 32'h0020_0140 + 32'(k * 2048), 0, 0);
    // mixed traffic over aliasing lines in two sets
    for (int i = 0; i < 250; i++) begin
      logic [31:0] a;
      logic [3:0]  be;
      a  = 32'(($urandom % 6) * 2048 + (($urandom % 2) ? 7 : 3) * 64 + ($urandom % 4) * 4);
      be = 4'($urandom % 15 + 1);
      access(($urandom % 3) == 0, a, $urandom, be);
    end
    // R9: only store writes and miss reads reached the lower level
    chk(wr_count == stores, "R9", "writes equal stores", 32'(wr_count), 32'(stores));
    chk(rd_count == misses, "R9", "reads equal load misses", 32'(rd_count), 32'(misses));
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule